// File: doc/BRIEF.md
# Six-Bit Carry-Save Array Multiplier

This block multiplies two unsigned 6-bit operands and returns the full 12-bit product. Each bit of the multiplier operand gates the multiplicand to form one partial-product row. The rows are folded in one at a time by a row of full adders that keeps a sum vector and a carry vector apart. Because no carry travels along a row, every reduction row settles one finished low-order product bit: the least significant bit of its sum vector.

Once the last row is absorbed, a ripple-carry chain of full adders merges the leftover sum and carry vectors into the upper half of the product. Every full adder forms its sum as the XOR of its three inputs. Its carry-out is (a AND b) OR (cin AND (a XOR b)).

A parameter chooses between a purely combinational output and a single output register that resets to zero. The block sits in a datapath wherever a short unsigned product is needed. Operands may change on every cycle.

Top module: `csa_mult6`

## Requirements
- R1: For operands `mcand` and `mplier`, each `OPW` = 6 bits wide, the product value is the exact unsigned product `mcand * mplier`, 2*`OPW` = 12 bits wide, for all 4096 operand pairs.
- R2: Product bit 0 equals `mcand[0] AND mplier[0]`.
- R3: When either operand is zero, the product is zero.
- R4: When `mplier` has only bit k set, the product equals `mcand` shifted left by k. This holds for k = 0..5, and k = 0 gives `mcand` itself.
- R5: The carry-out of the final ripple-carry merge is always 0. The largest case is 63 * 63 = 3969, which fits in 12 bits.
- R6: With `REG_OUT` = 1, `product` is registered. It is 0 while `rst_n` is low. Afterwards it shows, one clock later, the product of the operands sampled at the rising edge of `clk`.
- R7: With `REG_OUT` = 0, `product` follows the operands combinationally, in the same cycle and with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| mcand | input | 6 | Unsigned multiplicand |
| mplier | input | 6 | Unsigned multiplier; each bit selects one partial-product row |
| product | output | 12 | Unsigned product |

## Verification
All 4096 operand pairs are applied, one per clock, to a combinational instance and a registered instance side by side. Zero operands separate a faulty row gate from a correct one. A single-bit multiplier exposes any wrong row weight, because it isolates one row. The all-ones pair drives the longest carry paths through both the carry-save rows and the final merge. Comparing the registered instance against the value from the previous cycle separates a correct one-cycle delay from a missing or doubled register.

// File: rtl/csa_mult6.sv
module csa_mult6 #(
  parameter int OPW     = 6,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   mcand,
  input  logic [OPW-1:0]   mplier,
  output logic [2*OPW-1:0] product
);

  localparam int PW = 2 * OPW;

  logic [PW-1:0] prod_c;
  logic          merge_cout;

  function automatic logic [1:0] fadd(input logic a, input logic b, input logic ci);
    return {(a & b) | (ci & (a ^ b)), a ^ b ^ ci};
  endfunction

  always_comb begin
    logic [OPW-1:0] sv, cv, nsv, ncv, row, sh;
    logic [1:0]     r;
    logic           rc;
    sv     = mcand & {OPW{mplier[0]}};
    cv     = '0;
    prod_c = '0;
    prod_c[0] = sv[0];
    for (int i = 1; i < OPW; i++) begin
      row = mcand & {OPW{mplier[i]}};
      sh  = sv >> 1;
      for (int j = 0; j < OPW; j++) begin
        r      = fadd(sh[j], cv[j], row[j]);
        nsv[j] = r[0];
        ncv[j] = r[1];
      end
      sv = nsv;
      cv = ncv;
      prod_c[i] = sv[0];
    end
    sh = sv >> 1;
    rc = 1'b0;
    for (int j = 0; j < OPW; j++) begin
      r = fadd(sh[j], cv[j], rc);
      prod_c[OPW+j] = r[0];
      rc = r[1];
    end
    merge_cout = rc;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) product <= '0;
        else        product <= prod_c;
      end

      assert_reg_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> product == $past(prod_c));
    end else begin : g_comb
      assign product = prod_c;

      assert_comb_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        product == PW'(mcand) * PW'(mplier));
    end
  endgenerate

  assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prod_c == PW'(mcand) * PW'(mplier));

  assert_lsb_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prod_c[0] == (mcand[0] & mplier[0]));

  assert_zero_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mcand == '0 || mplier == '0) |-> prod_c == '0);

  assert_onehot_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mplier) == 1) |-> prod_c == ((PW'(mcand) * PW'(mplier))));

  assert_merge_carry_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !merge_cout);

endmodule

// File: tb/test_csa_mult6.sv
module test_csa_mult6;
  localparam int CLK_PERIOD = 10;
  localparam int OPW = 6;
  localparam int PW  = 2 * OPW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [OPW-1:0] a = '0;
  logic [OPW-1:0] b = '0;
  logic [PW-1:0]  p_comb, p_reg;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  int reg_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_mult6 #(.OPW(OPW), .REG_OUT(1'b0)) i_csa_mult6 (
    .clk(clk), .rst_n(rst_n), .mcand(a), .mplier(b), .product(p_comb));

  csa_mult6 #(.OPW(OPW), .REG_OUT(1'b1)) i_csa_mult6_reg (
    .clk(clk), .rst_n(rst_n), .mcand(a), .mplier(b), .product(p_reg));

  task automatic check(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(int'(p_reg), 0, "R6 reset value");
    check(int'(p_comb), 0, "R3 zero operands in reset");
    @(negedge clk);
    rst_n = 1'b1;
    reg_q.push_back(0);
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        int exp;
        string tag;
        @(negedge clk);
        a = OPW'(x);
        b = OPW'(y);
        #1;
        exp = x * y;
        if (x == 0 || y == 0)              tag = "R3 zero operand";
        else if (x == 63 && y == 63)       tag = "R5 largest product";
        else if ((y & (y - 1)) == 0)       tag = "R4 single-bit multiplier";
        else                               tag = "R1 exact product";
        check(int'(p_comb), exp, tag);
        check(int'(p_comb[0]), (x & y) & 1, "R2 product bit 0");
        if (x == 5 && y == 9) check(int'(p_comb), 45, "R7 same-cycle output");
        check(int'(p_reg), reg_q.pop_front(), "R6 registered one-cycle delay");
        reg_q.push_back(exp);
      end
    end
    @(negedge clk);
    #1;
    check(int'(p_reg), reg_q.pop_front(), "R6 last registered product");
    finished = 1'b1;
    finish_run();
  end
endmodule